// File: doc/BRIEF.md
# DMA Block Progress Counter

This block follows the progress of one DMA channel through a block transfer. A block is a number of frames, and each frame is a number of elements. Both counts use a value-plus-one encoding, so a programmed count of N means N+1 of them. A start strobe loads the initial frame and element counts. After that, every read-completion strobe moves the counters forward by one element.

The block raises a flag while the current element is the last one of its frame. It pulses a flag when the final element of the block has been read. When autoinitialization is enabled, the counters reload themselves from a separate pair of reload values at the end of each block, so the channel can run blocks back to back. The reload inputs are sampled only at the moment the block ends. They may change at any time while a block is running, and whatever value they hold at the end of the block is the one used.

Addressing, double-word handling and arbitration belong to neighbouring logic. A 32-bit double-word element arrives as one read-completion strobe and is counted as one element.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, `active_o`, `last_elem_o` and `block_done_o` are all low.
- R2: A `start_i` strobe loads `init_elems_i` and `init_frames_i` and raises `active_o` from the next cycle. A programmed element count of N gives N+1 read strobes per frame.
- R3: While active, `last_elem_o` is high exactly when N read strobes have been taken in the current frame, and it stays high until the next strobe.
- R4: A programmed frame count of F gives F+1 frames. A frame count of 0 gives a single frame, and the element count is restored to its programmed value at every frame boundary.
- R5: An element count of all ones (0xFFFF at the default width) gives 65536 elements in a frame.
- R6: `block_done_o` is high for exactly the one cycle that follows the final read strobe of a block. If `autoinit_i` is low at that strobe, `active_o` goes low in that same cycle.
- R7: If `autoinit_i` is high at the final strobe, `active_o` stays high and a new block begins. The new block takes its frame count from `rld_frames_i` and its element count from `rld_elems_i`.
- R8: The reload values used are the ones present at the final strobe of the block. Values written earlier in the same block have no effect.
- R9: While idle, `rd_done_i` has no effect: `active_o`, `last_elem_o` and `block_done_o` stay low.
- R10: A `start_i` strobe during an active block discards the current progress, restarts with the new initial counts, and does not pulse `block_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that begins a block |
| init_frames_i | input | FRAME_W | Initial frame count, value plus one frames |
| init_elems_i | input | ELEM_W | Initial elements per frame, value plus one |
| rld_frames_i | input | FRAME_W | Frame count loaded at the end of a block when autoinit is on |
| rld_elems_i | input | ELEM_W | Element count loaded at the end of a block when autoinit is on |
| autoinit_i | input | 1 | Reload and continue at the end of a block |
| rd_done_i | input | 1 | Read completion of one element |
| last_elem_o | output | 1 | The next element read is the last of its frame |
| block_done_o | output | 1 | One-cycle pulse after the final read of a block |
| active_o | output | 1 | A block is in progress |

## Verification
The element counter is visible only through `last_elem_o`. A wrong element count shows up within the first frame, as a last-element flag that comes one or more strobes early or late. A wrong frame count, or a per-frame value that is not restored correctly, stays hidden until the block ends. It then shows as a `block_done_o` pulse on the wrong strobe, or as a second frame whose length differs from the first. A reload that is captured too early is seen only in the block that follows, as a changed flag pattern in that block.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic active;
        logic done;
    } seq_state_t;

endpackage

// File: rtl/dma_down_counter.sv
module dma_down_counter
    import dma_cnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_op_e      op_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op_i)
            CNT_LOAD: st_d.cnt = load_val_i;
            CNT_DEC:  st_d.cnt = st_q.cnt - ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign zero_o = (st_q.cnt == '0);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CNT_DEC) |-> (st_q.cnt != '0));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic blk_end_i,
    input  logic autoinit_i,
    output logic active_o,
    output logic done_o
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.active = 1'b1;
        end else if (blk_end_i) begin
            st_d.active = autoinit_i;
            st_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign done_o   = st_q.done;

    // R6
    stop_when_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end_i && !start_i && !autoinit_i) |=> (!active_o && done_o));

    // R7
    keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end_i && autoinit_i) |=> active_o);

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
    import dma_cnt_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int ELEM_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] init_frames_i,
    input  logic [ELEM_W-1:0]  init_elems_i,
    input  logic [FRAME_W-1:0] rld_frames_i,
    input  logic [ELEM_W-1:0]  rld_elems_i,
    input  logic               autoinit_i,
    input  logic               rd_done_i,
    output logic               last_elem_o,
    output logic               block_done_o,
    output logic               active_o
);

    typedef struct packed {
        logic [ELEM_W-1:0] per_frame;
    } top_state_t;

    top_state_t st_d, st_q;

    cnt_op_e           frm_op, elm_op;
    logic [FRAME_W-1:0] frm_val, frm_cnt;
    logic [ELEM_W-1:0]  elm_val, elm_cnt;
    logic               frm_zero, elm_zero;
    logic               rd_ok, frame_end, blk_end, active;

    assign rd_ok     = active && rd_done_i && !start_i;
    assign frame_end = rd_ok && elm_zero;
    assign blk_end   = frame_end && frm_zero;

    always_comb begin
        st_d    = st_q;
        frm_op  = CNT_HOLD;
        elm_op  = CNT_HOLD;
        frm_val = rld_frames_i;
        elm_val = st_q.per_frame;
        if (start_i) begin
            frm_op         = CNT_LOAD;
            frm_val        = init_frames_i;
            elm_op         = CNT_LOAD;
            elm_val        = init_elems_i;
            st_d.per_frame = init_elems_i;
        end else if (blk_end) begin
            if (autoinit_i) begin
                frm_op         = CNT_LOAD;
                elm_op         = CNT_LOAD;
                elm_val        = rld_elems_i;
                st_d.per_frame = rld_elems_i;
            end
        end else if (frame_end) begin
            frm_op = CNT_DEC;
            elm_op = CNT_LOAD;
        end else if (rd_ok) begin
            elm_op = CNT_DEC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dma_down_counter #(.W(FRAME_W)) i_frm_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (frm_op),
        .load_val_i (frm_val),
        .cnt_o      (frm_cnt),
        .zero_o     (frm_zero)
    );

    dma_down_counter #(.W(ELEM_W)) i_elm_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (elm_op),
        .load_val_i (elm_val),
        .cnt_o      (elm_cnt),
        .zero_o     (elm_zero)
    );

    dma_seq_ctrl i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .blk_end_i  (blk_end),
        .autoinit_i (autoinit_i),
        .active_o   (active),
        .done_o     (block_done_o)
    );

    assign active_o    = active;
    assign last_elem_o = active && elm_zero;

    // R6
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_done_o |-> $past(rd_done_i && active_o && !start_i));

    // R9
    idle_ignores_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !start_i) |=> (!active_o && !block_done_o));

    // R2
    start_activates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_o && !block_done_o));

    // R4
    frame_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frm_zero && !start_i) |=> (elm_cnt == $past(st_q.per_frame)));

    // R8
    reload_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && autoinit_i && !start_i) |=> (frm_cnt == $past(rld_frames_i)));

endmodule

// File: tb/test_dma_xfer_counter.sv
module test_dma_xfer_counter;

    localparam int FW = 8;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [FW-1:0] init_frames_i = '0;
    logic [EW-1:0] init_elems_i = '0;
    logic [FW-1:0] rld_frames_i = '0;
    logic [EW-1:0] rld_elems_i = '0;
    logic          autoinit_i = 1'b0;
    logic          rd_done_i = 1'b0;
    logic          last_elem_o, block_done_o, active_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_xfer_counter #(.FRAME_W(FW), .ELEM_W(EW)) i_dma_xfer_counter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .init_frames_i(init_frames_i), .init_elems_i(init_elems_i),
        .rld_frames_i(rld_frames_i), .rld_elems_i(rld_elems_i),
        .autoinit_i(autoinit_i), .rd_done_i(rd_done_i),
        .last_elem_o(last_elem_o), .block_done_o(block_done_o), .active_o(active_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe();
        rd_done_i = 1'b1;
        tick();
        rd_done_i = 1'b0;
    endtask

    task automatic start(input int f, input int e);
        init_frames_i = FW'(f);
        init_elems_i  = EW'(e);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    // Walk one block of f+1 frames with e+1 elements each
    task automatic run_block(input int f, input int e, input bit ai, input bit gaps);
        for (int fr = 0; fr <= f; fr++) begin
            for (int k = 0; k <= e; k++) begin
                check("R3 last_elem", last_elem_o, (k == e));
                check("R2 active", active_o, 1);
                check("R6 no early done", block_done_o, 0);
                strobe();
                if (gaps && !(fr == f && k == e)) tick();
            end
        end
        check("R6 done pulse", block_done_o, 1);
        check(ai ? "R7 stay active" : "R6 idle after block", active_o, ai);
        tick();
        check("R6 one-cycle done", block_done_o, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int bad;
        repeat (3) tick();
        // R1 reset state
        check("R1 active", active_o, 0);
        check("R1 last_elem", last_elem_o, 0);
        check("R1 block_done", block_done_o, 0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 R6 R7: sweep small counts, manual and autoinit
        for (int ai = 0; ai < 2; ai++) begin
            for (int f = 0; f < 4; f++) begin
                for (int e = 0; e < 4; e++) begin
                    rld_frames_i = FW'(f);
                    rld_elems_i  = EW'(e);
                    autoinit_i   = ai[0];
                    start(f, e);
                    run_block(f, e, ai[0], (f + e) % 2 == 1);
                    if (ai == 1) begin
                        autoinit_i = 1'b0;
                        run_block(f, e, 1'b0, 1'b0);
                    end
                end
            end
        end

        // R9 reads while idle are ignored
        for (int i = 0; i < 3; i++) begin
            strobe();
            check("R9 active", active_o, 0);
            check("R9 done", block_done_o, 0);
            check("R9 last_elem", last_elem_o, 0);
        end

        // R8 reload values changed mid-block: the final value counts
        autoinit_i   = 1'b1;
        rld_frames_i = FW'(2);
        rld_elems_i  = EW'(0);
        start(1, 1);
        strobe();
        strobe();
        rld_frames_i = FW'(0);
        rld_elems_i  = EW'(2);
        check("R8 last_elem", last_elem_o, 0);
        strobe();
        check("R8 last_elem", last_elem_o, 1);
        strobe();
        check("R8 done", block_done_o, 1);
        check("R7 active", active_o, 1);
        autoinit_i = 1'b0;
        tick();
        run_block(0, 2, 1'b0, 1'b0);

        // R10 restart during a block
        start(2, 3);
        strobe();
        strobe();
        start(0, 1);
        check("R10 no done on restart", block_done_o, 0);
        run_block(0, 1, 1'b0, 1'b0);

        // R5 full-width element count, single frame
        start(0, 65535);
        bad = 0;
        for (int k = 0; k < 65536; k++) begin
            if (last_elem_o != (k == 65535) || block_done_o != 1'b0) bad++;
            strobe();
        end
        check("R5 flag errors over 65536 elements", bad, 0);
        check("R5 done", block_done_o, 1);
        check("R5 idle", active_o, 0);

        summary();
        $finish;
    end

endmodule